// File: doc/BRIEF.md
# Sixteen-Channel Additive-Pulse PWM Generator

The block drives sixteen pulse-width-modulated outputs from one shared 256-count conversion period. The period is split into sixteen basic pulses of sixteen counts each. For every channel, an 8-bit data value is split into two nibbles. The high nibble gives the active length of each basic pulse. The low nibble gives the number of basic pulses that are stretched by one extra count. The extra counts are spread evenly over the period, so the filtered output has little ripple. The resulting ratio runs from 0/256 to 255/256.

Software reaches the block through a flat register port. It holds sixteen data registers and two polarity registers. Each polarity register carries one bit per channel and can invert that channel's output. A data value is copied into a per-channel shadow only at the period boundary, so each period uses one value from start to end. A stop input clears the data registers, the shadows and the period counter, and drives every output to its idle level. The polarity registers are kept while stop is high.

Top module: `pwm_unit`

## Requirements
- R1: While `rst` is high and after it is released, every data register and both polarity registers read 0x00. `pwmOut` is all zeros on the first edge after reset.
- R2: Register map. Addresses 0 to 15 are the data registers of channels 0 to 15. Address 16 is the polarity register for channels 0 to 7 (bit i maps to channel i). Address 17 is the polarity register for channels 8 to 15 (bit i maps to channel 8+i). A write with `wrEn` high takes effect on the clock edge. `rdData` shows the addressed register combinationally. Other addresses read 0x00, and writes to them change nothing.
- R3: A period counter steps once per clock from 0 to 255 and then wraps. After reset or stop is released, the n-th rising edge (n = 1, 2, ...) drives `pwmOut` for phase (n-1) mod 256. Phase bits 7:4 are the basic-pulse index k. Phase bits 3:0 are the position p within the pulse.
- R4: Before polarity is applied, a channel with shadow value {H,L} is active at phase (k,p) exactly when p < H + e. Here e = 1 when the bit-reversed 4-bit k is less than L, and e = 0 otherwise.
- R5: Over a whole period, a channel is active for exactly 16·H + L counts. The value 0xFF gives 255 active counts, so a full 256 is never reached. The value 0x00 is never active.
- R6: A data value written during a period takes effect from phase 0 of the next period. The shadow loads on the edge that leaves phase 255. It never changes in the middle of a period.
- R7: A polarity bit of 1 inverts its channel's output. A polarity bit of 0 leaves it active-high. A polarity write is reflected at `pwmOut` on the edge after the write edge.
- R8: While `stopReq` is high: the data registers and shadows clear to 0x00, data writes are ignored, and the counter holds at phase 0. `pwmOut` equals the polarity bits. The polarity registers keep their values and stay writable.
- R9: Once `stopReq` falls, counting restarts at phase 0 with the timing of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stopReq | input | 1 | Module stop or standby clear |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational) |
| pwmOut | output | 16 | PWM outputs, one per channel |

## Verification
Read data is due in the same cycle as the address, so the bench sets `addr` on a falling edge and compares `rdData` one time step later. `pwmOut` has one register after the phase counter. The value for phase c therefore appears after the edge at which the counter held c. A model clocked on the rising edge computes each expected output from the requirements and the pre-edge state, and the bench compares that value on the falling edge. A new data word shows up no earlier than the period after the next wrap. A polarity change shows up one edge after the write. The per-period totals are summed over whole aligned periods only.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int NIB_W        = 4;
  parameter int DATA_W       = 2 * NIB_W;
  parameter int PHASE_W      = DATA_W;
  parameter int POL_W        = 8;
  parameter int PWM_CHANNELS = 16;
  parameter int PWM_ADDR_W   = 5;

  typedef struct packed {
    logic               clear;
    logic               load;
    logic [PHASE_W-1:0] phase;
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = PWM_CHANNELS,
  parameter int ADDR_W = PWM_ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           stopReq,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_CH-1:0][DATA_W-1:0]  dataRegs,
  output logic [NUM_CH-1:0]              polVec,
  output pwm_strobe_t                    strobe
);
  localparam int POL_REGS = NUM_CH / POL_W;

  logic [PHASE_W-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (rst || stopReq) phaseCnt <= '0;
    else                phaseCnt <= phaseCnt + 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_data
    logic [DATA_W-1:0] dataQ;
    always_ff @(posedge clk) begin
      if (rst || stopReq)
        dataQ <= '0;
      else if (wrEn && addr == ADDR_W'(ch))
        dataQ <= wrData;
    end
    assign dataRegs[ch] = dataQ;
  end

  for (genvar j = 0; j < POL_REGS; j++) begin : g_pol
    logic [POL_W-1:0] polQ;
    always_ff @(posedge clk) begin
      if (rst)
        polQ <= '0;
      else if (wrEn && addr == ADDR_W'(NUM_CH + j))
        polQ <= wrData[POL_W-1:0];
    end
    assign polVec[j*POL_W +: POL_W] = polQ;
  end

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (addr == ADDR_W'(ch)) rdData = dataRegs[ch];
    for (int j = 0; j < POL_REGS; j++)
      if (addr == ADDR_W'(NUM_CH + j)) rdData = DATA_W'(polVec[j*POL_W +: POL_W]);
  end

  assign strobe.clear = stopReq;
  assign strobe.load  = (phaseCnt == '1);
  assign strobe.phase = phaseCnt;
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int NUM_CH = PWM_CHANNELS
) (
  input  logic                           clk,
  input  logic                           rst,
  input  pwm_strobe_t                    strobe,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  dataRegs,
  input  logic [NUM_CH-1:0]              polVec,
  output logic [NUM_CH-1:0][DATA_W-1:0]  shadowRegs,
  output logic [NUM_CH-1:0]              pwmOut
);
  logic [NIB_W-1:0] pulseIdx, pulsePos, idxRev;

  assign pulseIdx = strobe.phase[PHASE_W-1:NIB_W];
  assign pulsePos = strobe.phase[NIB_W-1:0];

  always_comb begin
    for (int b = 0; b < NIB_W; b++) idxRev[b] = pulseIdx[NIB_W-1-b];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DATA_W-1:0] shadowQ;
    logic [NIB_W-1:0]  dutyHi, extraLo;
    logic              addExtra, activeNow, outQ;
    logic [NIB_W:0]    limit;

    assign dutyHi    = shadowQ[DATA_W-1:NIB_W];
    assign extraLo   = shadowQ[NIB_W-1:0];
    assign addExtra  = (idxRev < extraLo);
    assign limit     = {1'b0, dutyHi} + {{NIB_W{1'b0}}, addExtra};
    assign activeNow = ({1'b0, pulsePos} < limit);

    always_ff @(posedge clk) begin
      if (rst) begin
        shadowQ <= '0;
        outQ    <= 1'b0;
      end else if (strobe.clear) begin
        shadowQ <= '0;
        outQ    <= polVec[ch];
      end else begin
        if (strobe.load) shadowQ <= dataRegs[ch];
        outQ <= activeNow ^ polVec[ch];
      end
    end

    assign shadowRegs[ch] = shadowQ;
    assign pwmOut[ch]     = outQ;
  end
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
  import pwm_pkg::*;
#(
  parameter int NUM_CH = PWM_CHANNELS,
  parameter int ADDR_W = PWM_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stopReq,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  logic [NUM_CH-1:0][DATA_W-1:0] dataRegs;
  logic [NUM_CH-1:0][DATA_W-1:0] shadowRegs;
  logic [NUM_CH-1:0]             polVec;
  pwm_strobe_t                   strobe;

  pwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .stopReq(stopReq), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .dataRegs(dataRegs), .polVec(polVec),
    .strobe(strobe)
  );

  pwm_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .dataRegs(dataRegs),
    .polVec(polVec), .shadowRegs(shadowRegs), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_unit_chk.sv
module pwm_unit_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = PWM_CHANNELS
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          stopReq,
  input logic                          wrEn,
  input logic [NUM_CH-1:0]             pwmOut,
  input logic [NUM_CH-1:0]             polVec,
  input logic [NUM_CH-1:0][DATA_W-1:0] dataRegs,
  input logic [NUM_CH-1:0][DATA_W-1:0] shadowRegs,
  input logic [PHASE_W-1:0]            phase
);
  // R1: outputs are low on the first edge out of reset
  a_r1_reset_out_low: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pwmOut == '0);

  // R3: counter advances by one each running cycle
  a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stopReq)) |-> phase == PHASE_W'($past(phase) + 1'b1));

  // R6: shadows stay fixed except across a period boundary
  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |-> $stable(shadowRegs));

  // R7: polarity bits change only through a write
  a_r7_pol_write_only: assert property (@(posedge clk) disable iff (rst)
    !$past(wrEn) |-> $stable(polVec));

  // R8: stop drives outputs to the polarity level
  a_r8_stop_level: assert property (@(posedge clk) disable iff (rst)
    ($past(stopReq) && !$past(rst)) |-> pwmOut == $past(polVec));

  // R8: stop clears the data registers
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (rst)
    stopReq |=> dataRegs == '0);
endmodule

bind pwm_unit pwm_unit_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk(clk), .rst(rst), .stopReq(stopReq), .wrEn(wrEn), .pwmOut(pwmOut),
  .polVec(polVec), .dataRegs(dataRegs), .shadowRegs(shadowRegs),
  .phase(strobe.phase)
);

// File: tb/test_pwm_unit.sv
`timescale 1ns/1ps
module test_pwm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stopReq = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [15:0] pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_unit i_pwm_unit (
    .clk(clk), .rst(rst), .stopReq(stopReq), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  // R4: active test for phase (k,p) with value {H,L}
  function automatic logic actBit(logic [7:0] ph, logic [7:0] v);
    logic [3:0] k, rev;
    int lim;
    k = ph[7:4];
    for (int b = 0; b < 4; b++) rev[b] = k[3-b];
    lim = int'(v[7:4]) + ((rev < v[3:0]) ? 1 : 0);
    return int'(ph[3:0]) < lim;
  endfunction

  // Reference state, updated from the requirements at each rising edge
  logic [15:0][7:0] mData, mSh, expSh;
  logic [15:0]      mPol, expPol, expOut, tmp;
  logic [7:0]       mPh, expPh;
  logic             expValid = 0, expRun = 0;

  always @(posedge clk) begin
    expValid <= 1'b1;
    if (rst) begin
      mData <= '0; mSh <= '0; mPol <= '0; mPh <= '0;
      expOut <= '0; expRun <= 1'b0;
    end else begin
      if (stopReq) begin
        expOut <= mPol; expRun <= 1'b0; mPh <= '0; mData <= '0; mSh <= '0;
      end else begin
        for (int ch = 0; ch < 16; ch++) tmp[ch] = actBit(mPh, mSh[ch]) ^ mPol[ch];
        expOut <= tmp; expRun <= 1'b1; expPh <= mPh; expSh <= mSh; expPol <= mPol;
        mPh <= mPh + 8'd1;
        if (mPh == 8'hFF) mSh <= mData;
        if (wrEn && addr < 5'd16) mData[addr[3:0]] <= wrData;
      end
      if (wrEn && addr == 5'd16) mPol[7:0]  <= wrData;
      if (wrEn && addr == 5'd17) mPol[15:8] <= wrData;
    end
  end

  int  acc [16];
  bit  aligned = 0;

  always @(negedge clk) begin
    if (expValid && !done) begin
      checks++;
      if (pwmOut !== expOut) begin
        errors++;
        $display("FAIL R3/R4/R6/R7/R8/R9 per-cycle pwmOut=%h expected=%h", pwmOut, expOut);
      end
      if (expRun) begin
        if (expPh == 8'd0) aligned = 1;
        for (int ch = 0; ch < 16; ch++) begin
          if (expPh == 8'd0) acc[ch] = 0;
          acc[ch] += int'(pwmOut[ch] ^ expPol[ch]);
        end
        if (aligned && expPh == 8'hFF) begin
          for (int ch = 0; ch < 16; ch++) begin
            checks++;
            if (acc[ch] != 16 * int'(expSh[ch][7:4]) + int'(expSh[ch][3:0])) begin
              errors++;
              $display("FAIL R5 ch%0d period count=%0d expected=%0d", ch, acc[ch],
                       16 * int'(expSh[ch][7:4]) + int'(expSh[ch][3:0]));
            end
          end
        end
      end else aligned = 0;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d rdData=%h expected=%h", req, a, rdData, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(5);
    for (int a = 0; a < 18; a++) rdChk(5'(a), 8'h00, "R1");
    checks++;
    if (pwmOut !== 16'h0) begin
      errors++;
      $display("FAIL R1 pwmOut=%h expected=0000", pwmOut);
    end
    @(negedge clk); rst = 1'b0;
    idle(3);

    // R2: map, readback, ignored addresses
    for (int a = 0; a < 16; a++) wr(5'(a), 8'(8'h11 * (a + 1)));
    wr(5'd20, 8'hEE);
    wr(5'd31, 8'h77);
    rdChk(5'd20, 8'h00, "R2");
    rdChk(5'd18, 8'h00, "R2");
    for (int a = 0; a < 16; a++) rdChk(5'(a), 8'(8'h11 * (a + 1)), "R2");
    wr(5'd16, 8'h5A); wr(5'd17, 8'hC3);
    rdChk(5'd16, 8'h5A, "R2"); rdChk(5'd17, 8'hC3, "R2");
    wr(5'd16, 8'h00); wr(5'd17, 8'h00);
    idle(300);

    // R4 R5 R6 R7: every data value on some channel, polarity varied
    for (int r = 0; r < 16; r++) begin
      for (int ch = 0; ch < 16; ch++) wr(5'(ch), 8'(r * 16 + ch));
      wr(5'd16, (r % 2) ? 8'hA5 : 8'h00);
      wr(5'd17, (r % 4 == 3) ? 8'h3C : 8'h00);
      idle(520 + 7 * r);
    end

    // R8: stop clears data, holds polarity, ignores data writes
    wr(5'd16, 8'h0F); wr(5'd17, 8'hF0);
    for (int ch = 0; ch < 16; ch++) wr(5'(ch), 8'hFF - 8'(ch));
    idle(400);
    @(negedge clk); stopReq = 1'b1;
    idle(3);
    rdChk(5'd0, 8'h00, "R8"); rdChk(5'd9, 8'h00, "R8");
    rdChk(5'd16, 8'h0F, "R8"); rdChk(5'd17, 8'hF0, "R8");
    wr(5'd3, 8'h99);
    rdChk(5'd3, 8'h00, "R8");
    wr(5'd16, 8'h81);
    rdChk(5'd16, 8'h81, "R8");
    idle(10);
    @(negedge clk); stopReq = 1'b0;
    // R9: restart from phase 0
    wr(5'd4, 8'h80); wr(5'd5, 8'h0F); wr(5'd6, 8'hFF);
    idle(800);

    // R1: reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    idle(3);
    rdChk(5'd4, 8'h00, "R1"); rdChk(5'd16, 8'h00, "R1");
    @(negedge clk); rst = 1'b0;
    idle(20);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog expired: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule